// File: doc/BRIEF.md
# Auto-Delayed Compare Unit

This block is one compare channel of a timer. It does not hold the counter; it watches the counter value presented to it and produces a one-cycle match pulse. In standard mode the pulse follows every cycle in which the counter equals the programmed compare value. In the three auto-delayed modes the channel sleeps until an event arms it. The event is a capture strobe, or, in two of the modes, a match strobe from another compare channel that serves as a timeout. The armed target is the event's timestamp plus the programmed compare value, folded back into the counter's range. The unit fires once on that target and goes back to sleep.

The timestamp of a capture is the captured value that comes with the strobe. The timestamp of a timeout is the counter value in the cycle of the timeout strobe. A counter reset or period roll-over cancels any pending target, so a delayed match never leaks into the next counting period. The mode is a two-bit field. It can be loaded only while the counter is stopped.

Top module: `auto_delay_cmp`

## Requirements
- R1: After reset `match_pulse` is 0, `mode_q` is 00 (standard) and no delayed target is pending.
- R2: A mode write (`mode_wr` high) loads `mode_in` into `mode_q` only when `cnt_en` is low. While `cnt_en` is high the write is ignored and `mode_q` keeps its value. Encodings: 00 standard, 01 capture only, 10 capture or timeout from strobe A, 11 capture or timeout from strobe B.
- R3: In mode 00, `match_pulse` is high for exactly the cycle after each cycle in which `cnt_en` is high and `cnt_val` equals `cmp_val`. Capture and timeout strobes have no effect in this mode.
- R4: In modes 01, 10 and 11, a capture strobe with `cnt_en` high arms the unit with target `cap_val + cmp_val`. The pulse comes in the cycle after `cnt_val` first equals that target. Before any arming event, `cnt_val == cmp_val` gives no pulse.
- R5: The target wraps at the period. If `stamp + cmp_val` exceeds `period`, the target is `stamp + cmp_val - period - 1`.
- R6: An armed unit fires a single pulse and then disarms. A later cycle with `cnt_val` equal to the old target gives no pulse.
- R7: In mode 10, a `cmpa_hit` strobe while disarmed arms the unit with target `cnt_val + cmp_val`, where `cnt_val` is taken in the strobe's cycle.
- R8: In mode 11 the timeout source is `cmpb_hit` and `cmpa_hit` has no effect. In mode 01 neither strobe arms the unit.
- R9: If a capture and a timeout strobe arrive in the same cycle, the target is computed from the capture.
- R10: While armed, a timeout strobe is ignored and the target is kept. A new capture re-arms the unit with a fresh target.
- R11: In the auto modes, `cnt_rollover` clears the pending target. A match that falls in the roll-over cycle gives no pulse, and a capture in that cycle does not arm.
- R12: While `cnt_en` is low, no pulse is produced and capture or timeout strobes do not arm the unit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cnt_en | input | 1 | Counter running |
| cnt_val | input | W | Current counter value |
| period | input | W | Counter period (the last value before roll-over) |
| cnt_rollover | input | 1 | Counter reset or roll-over to zero in this cycle |
| cmp_val | input | W | Programmed compare value or delay |
| mode_wr | input | 1 | Mode write strobe |
| mode_in | input | 2 | Mode value to write |
| cap_stb | input | 1 | Capture event strobe |
| cap_val | input | W | Counter value captured with the strobe |
| cmpa_hit | input | 1 | Match strobe from timeout source A |
| cmpb_hit | input | 1 | Match strobe from timeout source B |
| mode_q | output | 2 | Active mode |
| match_pulse | output | 1 | One-cycle compare match |

## Verification
The bench targets the cases where the arming logic can quietly do the wrong thing. A target that wraps past the period catches a design that forgets the fold and would never fire. A capture in the same cycle as a timeout catches a design that takes the counter value as the timestamp and fires 20 counts late. A timeout while armed, and a second match on a spent target, catch a design that re-arms or fires twice. A roll-over and a mode write while running catch designs that let a stale target survive into the next period or let the mode change under a live counter.

// File: rtl/adc_pkg.sv
package adc_pkg;

  typedef enum logic [1:0] {
    MODE_STD    = 2'b00,
    MODE_CAP    = 2'b01,
    MODE_CAP_TA = 2'b10,
    MODE_CAP_TB = 2'b11
  } adc_mode_e;

  function automatic logic mode_is_auto(adc_mode_e m);
    return m != MODE_STD;
  endfunction

  function automatic logic mode_has_tmo_a(adc_mode_e m);
    return m == MODE_CAP_TA;
  endfunction

  function automatic logic mode_has_tmo_b(adc_mode_e m);
    return m == MODE_CAP_TB;
  endfunction

endpackage

// File: rtl/adc_mode_reg.sv
module adc_mode_reg
  import adc_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      cnt_en,
  input  logic      mode_wr,
  input  logic [1:0] mode_in,
  output adc_mode_e mode_q
);

  logic wr_ok;

  // the mode may only move while the counter is stopped
  assign wr_ok = mode_wr && !cnt_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     mode_q <= MODE_STD;
    else if (wr_ok) mode_q <= adc_mode_e'(mode_in);
  end

endmodule

// File: rtl/adc_arm_ctrl.sv
module adc_arm_ctrl
  import adc_pkg::*;
#(
  parameter int W = 16
)(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cnt_en,
  input  adc_mode_e    mode,
  input  logic         rollover,
  input  logic         cap_stb,
  input  logic [W-1:0] cap_val,
  input  logic         cmpa_hit,
  input  logic         cmpb_hit,
  input  logic [W-1:0] cnt_val,
  input  logic [W-1:0] cmp_val,
  input  logic [W-1:0] period,
  input  logic         fire,
  output logic         armed,
  output logic [W-1:0] target,
  output logic         cap_ev,
  output logic         tmo_ev,
  output logic         trig_ev,
  output logic         src_is_cap
);

  localparam int SW = W + 1;

  // stamp + delay, folded into 0..period
  function automatic logic [W-1:0] wrap_add(input logic [W-1:0] stamp,
                                            input logic [W-1:0] dly,
                                            input logic [W-1:0] per);
    logic [SW-1:0] sum;
    logic [SW-1:0] per_x;
    sum   = {1'b0, stamp} + {1'b0, dly};
    per_x = {1'b0, per};
    if (sum > per_x) sum = sum - per_x - SW'(1);
    return sum[W-1:0];
  endfunction

  logic         auto_m;
  logic         tmo_src;
  logic [W-1:0] stamp;
  logic [W-1:0] next_target;

  assign auto_m     = mode_is_auto(mode);
  assign tmo_src    = (mode_has_tmo_a(mode) && cmpa_hit) ||
                      (mode_has_tmo_b(mode) && cmpb_hit);
  assign cap_ev     = cnt_en && auto_m && cap_stb;
  assign tmo_ev     = cnt_en && tmo_src && !armed;
  assign trig_ev    = cap_ev || tmo_ev;
  assign src_is_cap = cap_ev;
  assign stamp      = src_is_cap ? cap_val : cnt_val;
  assign next_target = wrap_add(stamp, cmp_val, period);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed  <= 1'b0;
      target <= '0;
    end else if (rollover || !auto_m) begin
      armed  <= 1'b0;
    end else if (trig_ev) begin
      armed  <= 1'b1;
      target <= next_target;
    end else if (fire) begin
      armed  <= 1'b0;
    end
  end

endmodule

// File: rtl/adc_match.sv
module adc_match
  import adc_pkg::*;
#(
  parameter int W = 16
)(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cnt_en,
  input  adc_mode_e    mode,
  input  logic         rollover,
  input  logic         armed,
  input  logic [W-1:0] target,
  input  logic [W-1:0] cnt_val,
  input  logic [W-1:0] cmp_val,
  output logic         fire,
  output logic         std_hit,
  output logic         match_pulse
);

  logic auto_m;

  assign auto_m  = mode_is_auto(mode);
  assign std_hit = !auto_m && cnt_en && (cnt_val == cmp_val);
  assign fire    = auto_m && armed && cnt_en && !rollover && (cnt_val == target);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) match_pulse <= 1'b0;
    else        match_pulse <= std_hit || fire;
  end

endmodule

// File: rtl/auto_delay_cmp.sv
module auto_delay_cmp
  import adc_pkg::*;
#(
  parameter int W = 16
)(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cnt_en,
  input  logic [W-1:0] cnt_val,
  input  logic [W-1:0] period,
  input  logic         cnt_rollover,
  input  logic [W-1:0] cmp_val,
  input  logic         mode_wr,
  input  logic [1:0]   mode_in,
  input  logic         cap_stb,
  input  logic [W-1:0] cap_val,
  input  logic         cmpa_hit,
  input  logic         cmpb_hit,
  output logic [1:0]   mode_q,
  output logic         match_pulse
);

  adc_mode_e    mode;
  logic         armed;
  logic [W-1:0] target;
  logic         cap_ev;
  logic         tmo_ev;
  logic         trig_ev;
  logic         src_is_cap;
  logic         fire;
  logic         std_hit;

  adc_mode_reg u_mode (
    .clk     (clk),
    .rst_n   (rst_n),
    .cnt_en  (cnt_en),
    .mode_wr (mode_wr),
    .mode_in (mode_in),
    .mode_q  (mode)
  );

  adc_arm_ctrl #(.W(W)) u_arm (
    .clk        (clk),
    .rst_n      (rst_n),
    .cnt_en     (cnt_en),
    .mode       (mode),
    .rollover   (cnt_rollover),
    .cap_stb    (cap_stb),
    .cap_val    (cap_val),
    .cmpa_hit   (cmpa_hit),
    .cmpb_hit   (cmpb_hit),
    .cnt_val    (cnt_val),
    .cmp_val    (cmp_val),
    .period     (period),
    .fire       (fire),
    .armed      (armed),
    .target     (target),
    .cap_ev     (cap_ev),
    .tmo_ev     (tmo_ev),
    .trig_ev    (trig_ev),
    .src_is_cap (src_is_cap)
  );

  adc_match #(.W(W)) u_match (
    .clk         (clk),
    .rst_n       (rst_n),
    .cnt_en      (cnt_en),
    .mode        (mode),
    .rollover    (cnt_rollover),
    .armed       (armed),
    .target      (target),
    .cnt_val     (cnt_val),
    .cmp_val     (cmp_val),
    .fire        (fire),
    .std_hit     (std_hit),
    .match_pulse (match_pulse)
  );

  assign mode_q = mode;

endmodule

// File: rtl/adc_checker.sv
module adc_checker #(
  parameter int W = 16
)(
  input logic         clk,
  input logic         rst_n,
  input logic         cnt_en,
  input logic [W-1:0] cnt_val,
  input logic [W-1:0] cmp_val,
  input logic         cnt_rollover,
  input logic         cap_stb,
  input logic [1:0]   mode_q,
  input logic         match_pulse,
  input logic         armed,
  input logic [W-1:0] target,
  input logic         cap_ev,
  input logic         trig_ev,
  input logic         src_is_cap,
  input logic         fire
);

  AST_MODE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cnt_en) |-> $stable(mode_q)); // R2

  AST_STD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == 2'b00 && cnt_en && cnt_val == cmp_val) |=> match_pulse); // R3

  AST_AUTO_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
    (match_pulse && mode_q != 2'b00) |-> $past(armed)); // R6

  AST_DISARM_AFTER_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !trig_ev && !cnt_rollover) |=> !armed); // R6

  AST_CAP_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_en && cap_stb && mode_q != 2'b00) |-> (src_is_cap && cap_ev)); // R9

  AST_HOLD_WHILE_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !cap_ev && !cnt_rollover && !fire) |=> (armed && $stable(target))); // R10

  AST_ROLL_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_rollover |=> !armed); // R11

  AST_EN_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    match_pulse |-> $past(cnt_en)); // R12

endmodule

bind auto_delay_cmp adc_checker #(.W(W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cnt_en       (cnt_en),
  .cnt_val      (cnt_val),
  .cmp_val      (cmp_val),
  .cnt_rollover (cnt_rollover),
  .cap_stb      (cap_stb),
  .mode_q       (mode_q),
  .match_pulse  (match_pulse),
  .armed        (armed),
  .target       (target),
  .cap_ev       (cap_ev),
  .trig_ev      (trig_ev),
  .src_is_cap   (src_is_cap),
  .fire         (fire)
);

// File: tb/tb_auto_delay_cmp.sv
module tb_auto_delay_cmp;

  localparam int W      = 16;
  localparam int CLK_NS = 10;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cnt_en = 1'b0;
  logic [W-1:0] cnt_val = '0;
  logic [W-1:0] period = 16'd99;
  logic         cnt_rollover = 1'b0;
  logic [W-1:0] cmp_val = 16'd10;
  logic         mode_wr = 1'b0;
  logic [1:0]   mode_in = 2'b00;
  logic         cap_stb = 1'b0;
  logic [W-1:0] cap_val = '0;
  logic         cmpa_hit = 1'b0;
  logic         cmpb_hit = 1'b0;
  logic [1:0]   mode_q;
  logic         match_pulse;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #(CLK_NS/2) clk = ~clk;

  auto_delay_cmp #(.W(W)) dut (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .cnt_val(cnt_val),
    .period(period), .cnt_rollover(cnt_rollover), .cmp_val(cmp_val),
    .mode_wr(mode_wr), .mode_in(mode_in), .cap_stb(cap_stb),
    .cap_val(cap_val), .cmpa_hit(cmpa_hit), .cmpb_hit(cmpb_hit),
    .mode_q(mode_q), .match_pulse(match_pulse)
  );

  task automatic chk(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s got=%0d exp=%0d", req, got, exp);
    end
  endtask

  // one cycle of stimulus; returns after the edge that samples it
  task automatic step(input logic en, input int cv, input logic cap,
                      input int capv, input logic a, input logic b,
                      input logic roll);
    @(negedge clk);
    cnt_en = en; cnt_val = W'(cv); cap_stb = cap; cap_val = W'(capv);
    cmpa_hit = a; cmpb_hit = b; cnt_rollover = roll;
    @(posedge clk);
    #1;
    @(negedge clk);
    cap_stb = 0; cmpa_hit = 0; cmpb_hit = 0; cnt_rollover = 0;
  endtask

  task automatic run_at(input int cv, input string req, input int exp);
    step(1, cv, 0, 0, 0, 0, 0);
    chk(req, int'(match_pulse), exp);
  endtask

  // load mode with the counter stopped; roll-over flushes any target
  task automatic set_mode(input logic [1:0] m);
    @(negedge clk);
    cnt_en = 0; mode_wr = 1; mode_in = m; cnt_rollover = 1;
    @(posedge clk);
    #1;
    @(negedge clk);
    mode_wr = 0; cnt_rollover = 0;
  endtask

  task automatic t_reset();
    chk("R1 pulse", int'(match_pulse), 0);
    chk("R1 mode", int'(mode_q), 0);
    set_mode(2'b01);
    run_at(10, "R1 no stale target", 0);
    set_mode(2'b00);
  endtask

  task automatic t_standard();
    cmp_val = 20;
    run_at(19, "R3 below", 0);
    run_at(20, "R3 equal", 1);
    run_at(21, "R3 after", 0);
    step(1, 5, 1, 5, 1, 1, 0);
    run_at(15, "R3 capture no effect", 0);
    step(0, 20, 0, 0, 0, 0, 0);
    chk("R12 std disabled", int'(match_pulse), 0);
  endtask

  task automatic t_mode_lock();
    @(negedge clk);
    cnt_en = 1; mode_wr = 1; mode_in = 2'b01;
    @(posedge clk);
    #1;
    @(negedge clk);
    mode_wr = 0;
    chk("R2 write ignored", int'(mode_q), 0);
    set_mode(2'b01);
    chk("R2 write taken", int'(mode_q), 1);
  endtask

  task automatic t_capture();
    set_mode(2'b01);
    cmp_val = 10;
    run_at(10, "R4 unarmed", 0);
    step(1, 20, 1, 30, 0, 0, 0);
    chk("R4 arm cycle", int'(match_pulse), 0);
    run_at(39, "R4 early", 0);
    run_at(40, "R4 fire", 1);
    run_at(40, "R6 single", 0);
  endtask

  task automatic t_wrap();
    set_mode(2'b01);
    cmp_val = 10;
    step(1, 96, 1, 95, 0, 0, 0);
    run_at(105, "R5 unwrapped", 0);
    run_at(5, "R5 wrapped", 1);
  endtask

  task automatic t_timeouts();
    set_mode(2'b10);
    cmp_val = 10;
    step(1, 50, 0, 0, 1, 0, 0);
    run_at(60, "R7 tmo A", 1);
    set_mode(2'b01);
    step(1, 50, 0, 0, 1, 1, 0);
    run_at(60, "R8 mode01 no tmo", 0);
    set_mode(2'b11);
    step(1, 50, 0, 0, 1, 0, 0);
    run_at(60, "R8 mode11 A ignored", 0);
    step(1, 50, 0, 0, 0, 1, 0);
    run_at(60, "R8 tmo B", 1);
  endtask

  task automatic t_priority();
    set_mode(2'b10);
    cmp_val = 10;
    step(1, 50, 1, 30, 1, 0, 0);
    run_at(60, "R9 not tmo target", 0);
    run_at(40, "R9 capture target", 1);
  endtask

  task automatic t_armed();
    set_mode(2'b10);
    cmp_val = 10;
    step(1, 35, 1, 30, 0, 0, 0);
    step(1, 70, 0, 0, 1, 0, 0);
    run_at(80, "R10 tmo ignored", 0);
    run_at(40, "R10 kept target", 1);
    step(1, 42, 1, 30, 0, 0, 0);
    step(1, 52, 1, 50, 0, 0, 0);
    run_at(40, "R10 old target", 0);
    run_at(60, "R10 rearm", 1);
  endtask

  task automatic t_rollover();
    set_mode(2'b01);
    cmp_val = 10;
    step(1, 35, 1, 30, 0, 0, 0);
    step(1, 0, 0, 0, 0, 0, 1);
    run_at(40, "R11 cleared", 0);
    step(1, 35, 1, 30, 0, 0, 0);
    step(1, 40, 0, 0, 0, 0, 1);
    chk("R11 roll cycle", int'(match_pulse), 0);
    run_at(40, "R11 after roll", 0);
    step(1, 0, 1, 30, 0, 0, 1);
    run_at(40, "R11 capture on roll", 0);
  endtask

  task automatic t_disabled();
    set_mode(2'b10);
    cmp_val = 10;
    step(0, 35, 1, 30, 1, 0, 0);
    run_at(40, "R12 no arm", 0);
    step(1, 35, 1, 30, 0, 0, 0);
    step(0, 40, 0, 0, 0, 0, 0);
    chk("R12 no pulse", int'(match_pulse), 0);
  endtask

  initial begin
    #(CLK_NS * 100000);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog got=0 exp=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(posedge clk);
    #1;
    chk("R1 pulse after release", int'(match_pulse), 0);
    chk("R1 mode after release", int'(mode_q), 0);
    t_standard();
    t_mode_lock();
    t_capture();
    t_wrap();
    t_timeouts();
    t_priority();
    t_armed();
    t_rollover();
    t_disabled();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule